// File: doc/BRIEF.md
# Programmable Byte-Stuffing Escape Codec

This block sits on a serial byte path and hides reserved byte values from the link. It has two independent directions. The transmit side looks at each outgoing byte. When the byte equals one of the reserved characters and the escape rule for that character is switched on, the byte goes out as a two-byte replacement pair. The receive side does the reverse: it spots replacement pairs in the incoming stream and turns each one back into the single reserved character.

There are four rules. In the reference configuration they cover the frame separator, the escape lead byte itself, and the two software flow-control characters (resume and pause). Each rule has three programmable fields: a reserved byte, a lead byte and a tail byte. Each rule also has two enables, one per direction. All four streams (transmit in, transmit out, receive in, receive out) use a valid/ready handshake in which a byte moves on a clock edge where both valid and ready are high.

The configuration is taken from input ports and is expected to change only while both directions are idle. Framing, CRC and the serial line itself belong to neighbouring blocks.

Top module: `esc_codec`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the codec drives no output byte. No pair is pending on transmit, and the receive error flag is low.
- R2: Rule k occupies bits [8k+7:8k] of each of the three table inputs. With a rule enabled for transmit, an accepted byte equal to its reserved byte leaves as its lead byte and then its tail byte. Every other byte leaves unchanged, and order is kept. The reference tables are reserved {0xC0, 0xDB, 0x11, 0x13}, lead 0xDB for all four rules, and tail {0xDC, 0xDD, 0xDE, 0xDF} for rules 0..3.
- R3: While the tail byte of a pair waits on the transmit output, transmit-in ready is low and the output holds that tail byte.
- R4: A reserved byte whose rule has its transmit enable (bit k of the transmit enable input) low passes through unchanged as a single byte.
- R5: On receive, a lead byte followed by a tail byte that together form the pair of a rule enabled for receive leaves as that rule's reserved byte alone.
- R6: On receive, when a byte that is the lead byte of some enabled rule is followed by a byte that completes no enabled pair, both bytes leave unchanged and in order. The second byte is not examined as a new lead. The error output pulses high for exactly one cycle, in the cycle after that second byte is accepted.
- R7: A pair that belongs only to a rule whose receive enable (bit k of the receive enable input) is low is not collapsed. Its bytes leave unchanged.
- R8: When several enabled rules match the same byte (transmit) or the same pair (receive), the rule with the lowest index wins.
- R9: Under output backpressure no byte is lost or repeated in either direction, and a pending transmit tail byte stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_char_i | input | 32 | Reserved byte of each rule, rule k in bits [8k+7:8k] |
| cfg_lead_i | input | 32 | First byte of each replacement pair |
| cfg_tail_i | input | 32 | Second byte of each replacement pair |
| tx_en_i | input | 4 | Per-rule enable for transmit encoding |
| rx_en_i | input | 4 | Per-rule enable for receive decoding |
| tx_in_valid_i | input | 1 | Transmit source byte valid |
| tx_in_data_i | input | 8 | Transmit source byte |
| tx_in_ready_o | output | 1 | Codec accepts the transmit source byte |
| tx_out_valid_o | output | 1 | Encoded byte valid |
| tx_out_data_o | output | 8 | Encoded byte |
| tx_out_ready_i | input | 1 | Link takes the encoded byte |
| rx_in_valid_i | input | 1 | Received byte valid |
| rx_in_data_i | input | 8 | Received byte |
| rx_in_ready_o | output | 1 | Codec accepts the received byte |
| rx_out_valid_o | output | 1 | Decoded byte valid |
| rx_out_data_o | output | 8 | Decoded byte |
| rx_out_ready_i | input | 1 | Consumer takes the decoded byte |
| rx_err_o | output | 1 | One-cycle pulse on a broken replacement pair |

## Verification
On receive, detecting a broken pair and recognising a new lead byte can fall on the same byte. This happens when the byte after a lead is itself a lead value, as in 0xDB 0xDB 0xDC under the reference tables. The codec must flush that second byte verbatim rather than start a new pair with it. The case is provoked by a directed sequence and by random streams weighted heavily towards the shared lead value, all under random output backpressure. It is judged by comparing the decoded stream and the number of error pulses against a bench model written from R5 to R7.

// File: rtl/esc_codec_pkg.sv
package esc_codec_pkg;

  // Receive-side sequencing: passing bytes, holding a lead byte, flushing the
  // tail byte of a broken pair.
  typedef enum logic [1:0] {
    DEC_PASS  = 2'd0,
    DEC_LEAD  = 2'd1,
    DEC_FLUSH = 2'd2
  } dec_state_e;

endpackage

// File: rtl/esc_spec_match.sv
// Looks up one byte against the reserved-byte table; lowest enabled index wins.
module esc_spec_match #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_RULES = 4,
  localparam int unsigned TBL_W    = DATA_W * NUM_RULES
) (
  input  logic [DATA_W-1:0]    byte_i,
  input  logic [TBL_W-1:0]     char_tbl_i,
  input  logic [TBL_W-1:0]     lead_tbl_i,
  input  logic [TBL_W-1:0]     tail_tbl_i,
  input  logic [NUM_RULES-1:0] en_i,
  output logic                 hit_o,
  output logic [DATA_W-1:0]    lead_o,
  output logic [DATA_W-1:0]    tail_o
);

  function automatic logic [DATA_W-1:0] slot(input logic [TBL_W-1:0] tbl, input int unsigned k);
    return tbl[k*DATA_W +: DATA_W];
  endfunction

  logic [NUM_RULES-1:0] cand;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    assign cand[g] = en_i[g] && (slot(char_tbl_i, g) == byte_i);
  end

  always_comb begin
    hit_o  = |cand;
    lead_o = '0;
    tail_o = '0;
    for (int k = NUM_RULES - 1; k >= 0; k--) begin
      if (cand[k]) begin
        lead_o = slot(lead_tbl_i, k);
        tail_o = slot(tail_tbl_i, k);
      end
    end
  end

endmodule

// File: rtl/esc_pair_match.sv
// Receive lookups: is a byte any enabled lead, and does (held, byte) form an
// enabled pair (lowest index wins).
module esc_pair_match #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_RULES = 4,
  localparam int unsigned TBL_W    = DATA_W * NUM_RULES
) (
  input  logic [DATA_W-1:0]    cand_i,
  input  logic [DATA_W-1:0]    held_i,
  input  logic [TBL_W-1:0]     char_tbl_i,
  input  logic [TBL_W-1:0]     lead_tbl_i,
  input  logic [TBL_W-1:0]     tail_tbl_i,
  input  logic [NUM_RULES-1:0] en_i,
  output logic                 lead_hit_o,
  output logic                 pair_hit_o,
  output logic [DATA_W-1:0]    orig_o
);

  function automatic logic [DATA_W-1:0] slot(input logic [TBL_W-1:0] tbl, input int unsigned k);
    return tbl[k*DATA_W +: DATA_W];
  endfunction

  logic [NUM_RULES-1:0] lead_vec;
  logic [NUM_RULES-1:0] pair_vec;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    assign lead_vec[g] = en_i[g] && (slot(lead_tbl_i, g) == cand_i);
    assign pair_vec[g] = en_i[g] && (slot(lead_tbl_i, g) == held_i) &&
                         (slot(tail_tbl_i, g) == cand_i);
  end

  always_comb begin
    lead_hit_o = |lead_vec;
    pair_hit_o = |pair_vec;
    orig_o     = '0;
    for (int k = NUM_RULES - 1; k >= 0; k--) begin
      if (pair_vec[k]) orig_o = slot(char_tbl_i, k);
    end
  end

endmodule

// File: rtl/esc_encoder.sv
// Transmit direction: a matched byte leaves as lead then tail; input stalls
// while the tail byte is pending.
module esc_encoder #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_RULES = 4,
  localparam int unsigned TBL_W    = DATA_W * NUM_RULES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TBL_W-1:0]     char_tbl_i,
  input  logic [TBL_W-1:0]     lead_tbl_i,
  input  logic [TBL_W-1:0]     tail_tbl_i,
  input  logic [NUM_RULES-1:0] en_i,
  input  logic                 in_valid_i,
  input  logic [DATA_W-1:0]    in_data_i,
  output logic                 in_ready_o,
  output logic                 out_valid_o,
  output logic [DATA_W-1:0]    out_data_o,
  input  logic                 out_ready_i,
  output logic                 pend_o,
  output logic                 hit_o
);

  logic              pend_q;
  logic [DATA_W-1:0] tail_q;
  logic              hit;
  logic [DATA_W-1:0] lead_b;
  logic [DATA_W-1:0] tail_b;

  esc_spec_match #(.DATA_W(DATA_W), .NUM_RULES(NUM_RULES)) u_match (
    .byte_i    (in_data_i),
    .char_tbl_i(char_tbl_i),
    .lead_tbl_i(lead_tbl_i),
    .tail_tbl_i(tail_tbl_i),
    .en_i      (en_i),
    .hit_o     (hit),
    .lead_o    (lead_b),
    .tail_o    (tail_b)
  );

  always_comb begin
    if (pend_q) begin
      out_valid_o = 1'b1;
      out_data_o  = tail_q;
      in_ready_o  = 1'b0;
    end else begin
      out_valid_o = in_valid_i;
      out_data_o  = hit ? lead_b : in_data_i;
      in_ready_o  = out_ready_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tail_q <= '0;
    end else if (pend_q) begin
      if (out_ready_i) pend_q <= 1'b0;
    end else if (in_valid_i && out_ready_i && hit) begin
      pend_q <= 1'b1;
      tail_q <= tail_b;
    end
  end

  assign pend_o = pend_q;
  assign hit_o  = hit;

endmodule

// File: rtl/esc_decoder.sv
// Receive direction: collapses enabled pairs, flushes broken ones verbatim.
module esc_decoder
  import esc_codec_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_RULES = 4,
  localparam int unsigned TBL_W    = DATA_W * NUM_RULES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TBL_W-1:0]     char_tbl_i,
  input  logic [TBL_W-1:0]     lead_tbl_i,
  input  logic [TBL_W-1:0]     tail_tbl_i,
  input  logic [NUM_RULES-1:0] en_i,
  input  logic                 in_valid_i,
  input  logic [DATA_W-1:0]    in_data_i,
  output logic                 in_ready_o,
  output logic                 out_valid_o,
  output logic [DATA_W-1:0]    out_data_o,
  input  logic                 out_ready_i,
  output logic                 err_o,
  output logic                 collapse_o,
  output logic                 flush_o
);

  dec_state_e        st_q, st_d;
  logic [DATA_W-1:0] held_q;
  logic [DATA_W-1:0] tail_q;
  logic              err_q;
  logic              lead_hit;
  logic              pair_hit;
  logic [DATA_W-1:0] orig;
  logic              take_lead;
  logic              broken;

  esc_pair_match #(.DATA_W(DATA_W), .NUM_RULES(NUM_RULES)) u_pair (
    .cand_i    (in_data_i),
    .held_i    (held_q),
    .char_tbl_i(char_tbl_i),
    .lead_tbl_i(lead_tbl_i),
    .tail_tbl_i(tail_tbl_i),
    .en_i      (en_i),
    .lead_hit_o(lead_hit),
    .pair_hit_o(pair_hit),
    .orig_o    (orig)
  );

  assign take_lead = (st_q == DEC_PASS) && in_valid_i && lead_hit;
  assign broken    = (st_q == DEC_LEAD) && in_valid_i && out_ready_i && !pair_hit;

  always_comb begin
    st_d        = st_q;
    out_valid_o = 1'b0;
    out_data_o  = in_data_i;
    in_ready_o  = 1'b0;
    unique case (st_q)
      DEC_PASS: begin
        if (lead_hit) begin
          in_ready_o = 1'b1;
          if (in_valid_i) st_d = DEC_LEAD;
        end else begin
          out_valid_o = in_valid_i;
          in_ready_o  = out_ready_i;
        end
      end
      DEC_LEAD: begin
        out_valid_o = in_valid_i;
        out_data_o  = pair_hit ? orig : held_q;
        in_ready_o  = out_ready_i;
        if (in_valid_i && out_ready_i) st_d = pair_hit ? DEC_PASS : DEC_FLUSH;
      end
      DEC_FLUSH: begin
        out_valid_o = 1'b1;
        out_data_o  = tail_q;
        if (out_ready_i) st_d = DEC_PASS;
      end
      default: st_d = DEC_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= DEC_PASS;
      held_q <= '0;
      tail_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= broken;
      if (take_lead) held_q <= in_data_i;
      if (broken)    tail_q <= in_data_i;
    end
  end

  assign err_o      = err_q;
  assign collapse_o = (st_q == DEC_LEAD) && in_valid_i && pair_hit;
  assign flush_o    = (st_q == DEC_FLUSH);

endmodule

// File: rtl/esc_codec.sv
module esc_codec #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_RULES = 4,
  localparam int unsigned TBL_W    = DATA_W * NUM_RULES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TBL_W-1:0]     cfg_char_i,
  input  logic [TBL_W-1:0]     cfg_lead_i,
  input  logic [TBL_W-1:0]     cfg_tail_i,
  input  logic [NUM_RULES-1:0] tx_en_i,
  input  logic [NUM_RULES-1:0] rx_en_i,
  input  logic                 tx_in_valid_i,
  input  logic [DATA_W-1:0]    tx_in_data_i,
  output logic                 tx_in_ready_o,
  output logic                 tx_out_valid_o,
  output logic [DATA_W-1:0]    tx_out_data_o,
  input  logic                 tx_out_ready_i,
  input  logic                 rx_in_valid_i,
  input  logic [DATA_W-1:0]    rx_in_data_i,
  output logic                 rx_in_ready_o,
  output logic                 rx_out_valid_o,
  output logic [DATA_W-1:0]    rx_out_data_o,
  input  logic                 rx_out_ready_i,
  output logic                 rx_err_o
);

  // Internal events brought out for the checker.
  logic enc_pend;
  logic enc_hit;
  logic dec_collapse;
  logic dec_flush;

  esc_encoder #(.DATA_W(DATA_W), .NUM_RULES(NUM_RULES)) u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_tbl_i (cfg_char_i),
    .lead_tbl_i (cfg_lead_i),
    .tail_tbl_i (cfg_tail_i),
    .en_i       (tx_en_i),
    .in_valid_i (tx_in_valid_i),
    .in_data_i  (tx_in_data_i),
    .in_ready_o (tx_in_ready_o),
    .out_valid_o(tx_out_valid_o),
    .out_data_o (tx_out_data_o),
    .out_ready_i(tx_out_ready_i),
    .pend_o     (enc_pend),
    .hit_o      (enc_hit)
  );

  esc_decoder #(.DATA_W(DATA_W), .NUM_RULES(NUM_RULES)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_tbl_i (cfg_char_i),
    .lead_tbl_i (cfg_lead_i),
    .tail_tbl_i (cfg_tail_i),
    .en_i       (rx_en_i),
    .in_valid_i (rx_in_valid_i),
    .in_data_i  (rx_in_data_i),
    .in_ready_o (rx_in_ready_o),
    .out_valid_o(rx_out_valid_o),
    .out_data_o (rx_out_data_o),
    .out_ready_i(rx_out_ready_i),
    .err_o      (rx_err_o),
    .collapse_o (dec_collapse),
    .flush_o    (dec_flush)
  );

endmodule

// File: rtl/esc_codec_checker.sv
module esc_codec_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_in_valid_i,
  input logic              tx_in_ready_o,
  input logic              tx_out_valid_o,
  input logic [DATA_W-1:0] tx_out_data_o,
  input logic              tx_out_ready_i,
  input logic              rx_in_valid_i,
  input logic              rx_in_ready_o,
  input logic              rx_out_valid_o,
  input logic              rx_out_ready_i,
  input logic              rx_err_o,
  input logic              enc_pend,
  input logic              enc_hit,
  input logic              dec_collapse,
  input logic              dec_flush
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!enc_pend && !rx_err_o && !dec_flush));

  assert_tail_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_hit && tx_in_valid_i && tx_in_ready_o) |=> (enc_pend && tx_out_valid_o));

  assert_input_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_pend |-> !tx_in_ready_o);

  assert_tail_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_pend && !tx_out_ready_i) |=> (enc_pend && tx_out_valid_o && $stable(tx_out_data_o)));

  assert_pair_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_collapse && rx_out_ready_i) |=> !rx_err_o);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> ($past(rx_in_valid_i && rx_in_ready_o) && dec_flush));

  assert_flush_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_flush |-> (!rx_in_ready_o && rx_out_valid_o));

endmodule

bind esc_codec esc_codec_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_in_valid_i (tx_in_valid_i),
  .tx_in_ready_o (tx_in_ready_o),
  .tx_out_valid_o(tx_out_valid_o),
  .tx_out_data_o (tx_out_data_o),
  .tx_out_ready_i(tx_out_ready_i),
  .rx_in_valid_i (rx_in_valid_i),
  .rx_in_ready_o (rx_in_ready_o),
  .rx_out_valid_o(rx_out_valid_o),
  .rx_out_ready_i(rx_out_ready_i),
  .rx_err_o      (rx_err_o),
  .enc_pend      (enc_pend),
  .enc_hit       (enc_hit),
  .dec_collapse  (dec_collapse),
  .dec_flush     (dec_flush)
);

// File: tb/esc_codec_bench.sv
`timescale 1ns/1ps
module esc_codec_bench;
  localparam int NR   = 4;
  localparam int MAXN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_char, cfg_lead, cfg_tail;
  logic [3:0]  tx_en, rx_en;
  logic        tx_in_valid = 1'b0;
  logic [7:0]  tx_in_data = 8'h00;
  logic        tx_in_ready, tx_out_valid;
  logic [7:0]  tx_out_data;
  logic        tx_out_ready = 1'b0;
  logic        rx_in_valid = 1'b0;
  logic [7:0]  rx_in_data = 8'h00;
  logic        rx_in_ready, rx_out_valid;
  logic [7:0]  rx_out_data;
  logic        rx_out_ready = 1'b0;
  logic        rx_err;

  esc_codec u_esc_codec (
    .clk(clk), .rst_n(rst_n),
    .cfg_char_i(cfg_char), .cfg_lead_i(cfg_lead), .cfg_tail_i(cfg_tail),
    .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_in_valid_i(tx_in_valid), .tx_in_data_i(tx_in_data), .tx_in_ready_o(tx_in_ready),
    .tx_out_valid_o(tx_out_valid), .tx_out_data_o(tx_out_data), .tx_out_ready_i(tx_out_ready),
    .rx_in_valid_i(rx_in_valid), .rx_in_data_i(rx_in_data), .rx_in_ready_o(rx_in_ready),
    .rx_out_valid_o(rx_out_valid), .rx_out_data_o(rx_out_data), .rx_out_ready_i(rx_out_ready),
    .rx_err_o(rx_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;

  logic [7:0] esrc[MAXN]; int esrc_n;
  logic [7:0] eexp[MAXN]; int eexp_n;
  logic [7:0] egot[MAXN]; int egot_n = 0;
  logic [7:0] dsrc[MAXN]; int dsrc_n;
  logic [7:0] dexp[MAXN]; int dexp_n;
  logic [7:0] dgot[MAXN]; int dgot_n = 0;
  int derr_exp;
  int derr_got = 0;
  bit hold_pend = 0;
  logic [7:0] hold_byte;
  int hold_checks = 0;
  int hold_bad = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [7:0] fld(input logic [31:0] t, input int k);
    return t[k*8 +: 8];
  endfunction

  function automatic int tx_rule(input logic [7:0] b);
    for (int k = 0; k < NR; k++) if (tx_en[k] && fld(cfg_char, k) == b) return k;
    return -1;
  endfunction

  function automatic bit rx_is_lead(input logic [7:0] b);
    for (int k = 0; k < NR; k++) if (rx_en[k] && fld(cfg_lead, k) == b) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int rx_rule(input logic [7:0] a, input logic [7:0] b);
    for (int k = 0; k < NR; k++)
      if (rx_en[k] && fld(cfg_lead, k) == a && fld(cfg_tail, k) == b) return k;
    return -1;
  endfunction

  function automatic void enc_model();
    eexp_n = 0;
    for (int i = 0; i < esrc_n; i++) begin
      int k;
      k = tx_rule(esrc[i]);
      if (k >= 0) begin
        eexp[eexp_n] = fld(cfg_lead, k); eexp_n++;
        eexp[eexp_n] = fld(cfg_tail, k); eexp_n++;
      end else begin
        eexp[eexp_n] = esrc[i]; eexp_n++;
      end
    end
  endfunction

  function automatic void dec_model();
    int i;
    i = 0; dexp_n = 0; derr_exp = 0;
    while (i < dsrc_n) begin
      if (rx_is_lead(dsrc[i]) && i + 1 < dsrc_n) begin
        int k;
        k = rx_rule(dsrc[i], dsrc[i+1]);
        if (k >= 0) begin
          dexp[dexp_n] = fld(cfg_char, k); dexp_n++;
        end else begin
          dexp[dexp_n] = dsrc[i];   dexp_n++;
          dexp[dexp_n] = dsrc[i+1]; dexp_n++;
          derr_exp++;
        end
        i += 2;
      end else begin
        dexp[dexp_n] = dsrc[i]; dexp_n++;
        i++;
      end
    end
  endfunction

  function automatic logic [7:0] pick();
    case ($urandom_range(11))
      0: return 8'hC0; 1: return 8'hDB; 2: return 8'hDB; 3: return 8'h11;
      4: return 8'h13; 5: return 8'hDC; 6: return 8'hDD; 7: return 8'hDE;
      8: return 8'hDF; default: return 8'($urandom_range(255));
    endcase
  endfunction

  function automatic void ref_cfg();
    cfg_char = {8'h13, 8'h11, 8'hDB, 8'hC0};
    cfg_lead = {8'hDB, 8'hDB, 8'hDB, 8'hDB};
    cfg_tail = {8'hDF, 8'hDE, 8'hDD, 8'hDC};
  endfunction

  always @(posedge clk) begin
    #1;
    tx_out_ready = (ready_mode == 0) ? 1'b1 : ($urandom_range(2) != 0);
    rx_out_ready = (ready_mode == 0) ? 1'b1 : ($urandom_range(2) != 0);
  end

  // Monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_out_valid && tx_out_ready && egot_n < MAXN) begin egot[egot_n] = tx_out_data; egot_n++; end
      if (rx_out_valid && rx_out_ready && dgot_n < MAXN) begin dgot[dgot_n] = rx_out_data; dgot_n++; end
      if (rx_err) derr_got++;
      if (hold_pend) begin
        hold_checks++;
        if (tx_in_ready || !tx_out_valid || tx_out_data != hold_byte) hold_bad++;
        if (tx_out_ready) hold_pend = 0;
      end else if (tx_in_valid && tx_in_ready && tx_rule(tx_in_data) >= 0) begin
        hold_pend = 1;
        hold_byte = fld(cfg_tail, tx_rule(tx_in_data));
      end
    end
  end

  task automatic drive_tx();
    for (int i = 0; i < esrc_n; i++) begin
      tx_in_valid = 1'b1; tx_in_data = esrc[i];
      do @(negedge clk); while (!tx_in_ready);
      @(posedge clk); #1;
      tx_in_valid = 1'b0;
      if (ready_mode != 0 && $urandom_range(3) == 0) begin @(posedge clk); #1; end
    end
  endtask

  task automatic drive_rx();
    for (int i = 0; i < dsrc_n; i++) begin
      rx_in_valid = 1'b1; rx_in_data = dsrc[i];
      do @(negedge clk); while (!rx_in_ready);
      @(posedge clk); #1;
      rx_in_valid = 1'b0;
      if (ready_mode != 0 && $urandom_range(3) == 0) begin @(posedge clk); #1; end
    end
  endtask

  task automatic run_tx(input string req);
    enc_model();
    egot_n = 0;
    drive_tx();
    for (int t = 0; t < 100 && egot_n < eexp_n; t++) @(negedge clk);
    repeat (4) @(posedge clk);
    #1;
    check(egot_n == eexp_n, req, "tx byte count", egot_n, eexp_n);
    for (int i = 0; i < eexp_n && i < egot_n; i++) begin
      if (egot[i] != eexp[i]) begin
        check(1'b0, req, $sformatf("tx byte %0d", i), egot[i], eexp[i]);
        break;
      end
      if (i == eexp_n - 1) check(1'b1, req, "tx bytes", 0, 0);
    end
  endtask

  task automatic run_rx(input string req);
    dec_model();
    dgot_n = 0; derr_got = 0;
    drive_rx();
    for (int t = 0; t < 100 && dgot_n < dexp_n; t++) @(negedge clk);
    repeat (4) @(posedge clk);
    #1;
    check(dgot_n == dexp_n, req, "rx byte count", dgot_n, dexp_n);
    for (int i = 0; i < dexp_n && i < dgot_n; i++) begin
      if (dgot[i] != dexp[i]) begin
        check(1'b0, req, $sformatf("rx byte %0d", i), dgot[i], dexp[i]);
        break;
      end
      if (i == dexp_n - 1) check(1'b1, req, "rx bytes", 0, 0);
    end
    check(derr_got == derr_exp, req, "rx error pulses", derr_got, derr_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    ref_cfg();
    tx_en = 4'hF; rx_en = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet during reset
    check(!tx_out_valid && !rx_out_valid && !rx_err, "R1", "outputs in reset",
          {tx_out_valid, rx_out_valid, rx_err}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(!tx_out_valid && !rx_out_valid && !rx_err && tx_in_ready, "R1", "outputs after reset",
          {tx_out_valid, rx_out_valid, rx_err, tx_in_ready}, 1);

    // R2 directed, reference tables, literal expectations
    esrc[0] = 8'hC0; esrc[1] = 8'hDB; esrc[2] = 8'h11; esrc[3] = 8'h13; esrc[4] = 8'h55;
    esrc_n = 5;
    run_tx("R2");
    check(egot[0] == 8'hDB && egot[1] == 8'hDC && egot[2] == 8'hDB && egot[3] == 8'hDD &&
          egot[8] == 8'h55 && egot[7] == 8'hDF, "R2", "reference pairs", egot[1], 8'hDC);

    // R2/R3/R9 random with backpressure
    ready_mode = 1; hold_checks = 0; hold_bad = 0;
    esrc_n = 300;
    for (int i = 0; i < esrc_n; i++) esrc[i] = pick();
    run_tx("R9");
    check(hold_bad == 0 && hold_checks > 0, "R3", "input held during tail", hold_bad, 0);

    // R4: rules 1 and 3 disabled for transmit
    tx_en = 4'b0101;
    esrc[0] = 8'hDB; esrc[1] = 8'h13; esrc[2] = 8'hC0;
    esrc_n = 200;
    for (int i = 3; i < esrc_n; i++) esrc[i] = pick();
    run_tx("R4");
    check(egot[0] == 8'hDB && egot[1] == 8'h13 && egot[2] == 8'hDB && egot[3] == 8'hDC,
          "R4", "disabled rule passes", egot[1], 8'h13);
    tx_en = 4'hF;

    // R5/R6 directed decode: pairs, broken pair whose tail is itself a lead
    ready_mode = 0;
    dsrc[0] = 8'hDB; dsrc[1] = 8'hDC; dsrc[2] = 8'hDB; dsrc[3] = 8'hDF;
    dsrc[4] = 8'hDB; dsrc[5] = 8'hDB; dsrc[6] = 8'hDC; dsrc[7] = 8'h41; dsrc[8] = 8'h00;
    dsrc_n = 9;
    run_rx("R5");
    check(dgot[0] == 8'hC0 && dgot[1] == 8'h13 && dgot[2] == 8'hDB && dgot[3] == 8'hDB &&
          dgot[4] == 8'hDC && dgot_n == 7 && derr_got == 1, "R6", "broken pair flush",
          dgot[3], 8'hDB);

    // R6 random decode under backpressure
    ready_mode = 1;
    dsrc_n = 400;
    for (int i = 0; i < dsrc_n - 1; i++) dsrc[i] = pick();
    dsrc[dsrc_n-1] = 8'h00;
    run_rx("R6");

    // R7: rules 0 and 2 disabled for receive
    rx_en = 4'b1010;
    dsrc[0] = 8'hDB; dsrc[1] = 8'hDC; dsrc[2] = 8'h00;
    dsrc_n = 250;
    for (int i = 3; i < dsrc_n - 1; i++) dsrc[i] = pick();
    dsrc[dsrc_n-1] = 8'h00;
    run_rx("R7");
    check(dgot[0] == 8'hDB && dgot[1] == 8'hDC, "R7", "disabled pair not collapsed", dgot[1], 8'hDC);
    rx_en = 4'hF;

    // R8: overlapping rules, lowest index wins
    ready_mode = 0;
    cfg_char = {8'h02, 8'h7E, 8'h7E, 8'h01};
    cfg_lead = {8'hAA, 8'hA2, 8'hA1, 8'hAA};
    cfg_tail = {8'hBB, 8'hB2, 8'hB1, 8'hBB};
    esrc[0] = 8'h7E; esrc[1] = 8'h02; esrc_n = 2;
    run_tx("R8");
    check(egot[0] == 8'hA1 && egot[1] == 8'hB1, "R8", "tx priority", egot[1], 8'hB1);
    dsrc[0] = 8'hAA; dsrc[1] = 8'hBB; dsrc[2] = 8'h00; dsrc_n = 3;
    run_rx("R8");
    check(dgot[0] == 8'h01, "R8", "rx priority", dgot[0], 8'h01);

    summary();
    $finish;
  end

endmodule